// File: doc/BRIEF.md
# Reordering Memory Request Queue with Ingress Tags

This block holds up to eight pending memory read and write requests. It issues them in an order chosen for efficiency rather than the order in which they arrived. Each request arrives with an address, a read/write flag, an initiator source ID and a QoS class. On acceptance the queue stamps it with a wrapping ingress sequence number and with the value of a free-running cycle counter. Both tags stay attached to the entry, unchanged, until the entry is issued.

When an entry is chosen, its address and direction appear on the issue port. In the same cycle a log port presents the entry's preserved sequence number, timestamp, source ID and QoS class. The log port also gives a code that explains why this entry won, and a flag that is set when the entry overtook an older one. A downstream observer can therefore rebuild both the arrival order and the schedule.

The queue tracks one open row in each of four banks. The row is taken from the address fields: column in bits [3:0], bank in bits [5:4], row in bits [15:6].

Top module: `rq_reorder_queue`

## Requirements
- R1: `in_ready` is high exactly when fewer than 8 requests are held. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. A request offered while `in_ready` is low is dropped and leaves no trace.
- R2: Accepted requests receive sequence numbers 0, 1, 2, … after reset, in acceptance order, wrapping modulo 256. Reordering never alters them.
- R3: A request's timestamp is the cycle-counter value in its acceptance cycle. The counter is 0 in the first cycle after reset release and advances every cycle. The timestamp is never changed while the request waits.
- R4: An issued request presents the same address, write flag, source ID and QoS class it was accepted with.
- R5: The winner is chosen by comparing, in this order: the higher QoS class; then a row hit (the bank's open row is valid and equal to the request's row) over a miss; then a read over a write. Any remaining tie goes to the oldest entry.
- R6: After reset no bank has an open row. Each issue makes the issued request's row the open row of its bank, starting with the next cycle's choice.
- R7: `log_reason` is 0 when the oldest entry is issued. When a younger entry wins, it is 1 if the winner's QoS is higher than the oldest entry's, 2 if QoS is equal and only the winner hits, and 3 if QoS and hit status are equal and the winner is a read while the oldest is a write.
- R8: `log_skipped` is high exactly when the issued entry is not the oldest held entry.
- R9: `out_valid` is high exactly when at least one request is held. `log_valid` is high exactly in the cycles where `out_valid` and `out_ready` are both high, and the entry is removed at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Queue has room |
| in_write | input | 1 | 1 = write, 0 = read |
| in_addr | input | 16 | Request address (row, bank, column) |
| in_src | input | 4 | Initiator source ID |
| in_qos | input | 2 | QoS class, larger is more urgent |
| out_valid | output | 1 | A request is available to issue |
| out_ready | input | 1 | Downstream takes the request |
| out_write | output | 1 | Direction of the issued request |
| out_addr | output | 16 | Address of the issued request |
| log_valid | output | 1 | Log record strobe, one per issue |
| log_seq | output | 8 | Ingress sequence number |
| log_stamp | output | 16 | Arrival timestamp |
| log_src | output | 4 | Source ID |
| log_qos | output | 2 | QoS class |
| log_reason | output | 2 | Reason code for the pick |
| log_skipped | output | 1 | Issued entry was not the oldest |

## Verification
On every cycle, the embedded assertions check the following. The occupancy counter agrees with `in_ready` and `out_valid`. The sequence counter steps once per acceptance. A waiting entry keeps its tags, address and source. The chosen entry is valid and ranks no lower than the oldest one. Each issue loads the bank's open row.

Only the bench's reference model, running on mixed traffic, can show that the full priority order is right. The same applies to the exact reason code and skip flag for each issue, and to the exact timestamps and sequence values after long runs and wraps. The bench also confirms that every reason code actually occurs.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    RSN_OLDEST = 2'd0,
    RSN_QOS    = 2'd1,
    RSN_ROWHIT = 2'd2,
    RSN_READ   = 2'd3
  } rq_reason_e;
endpackage

// File: rtl/rq_open_rows.sv
module rq_open_rows #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          upd_en,
  input  logic [BANK_W-1:0]             upd_bank,
  input  logic [ROW_W-1:0]              upd_row,
  input  logic [DEPTH-1:0][BANK_W-1:0]  ent_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]   ent_row,
  output logic [DEPTH-1:0]              ent_hit
);
  localparam int BANKS = 1 << BANK_W;

  logic             open_vld_q [BANKS];
  logic [ROW_W-1:0] open_row_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = upd_en && (upd_bank == BANK_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_vld_q[b] <= 1'b0;
        open_row_q[b] <= '0;
      end else if (bank_we) begin
        open_vld_q[b] <= 1'b1;
        open_row_q[b] <= upd_row;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_hit[i] = open_vld_q[ent_bank[i]] && (open_row_q[ent_bank[i]] == ent_row[i]);
    end
  end

  // R6: an issue leaves its row open in its bank for the next pick
  p_row_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (open_vld_q[$past(upd_bank)] && open_row_q[$past(upd_bank)] == $past(upd_row)));
endmodule

// File: rtl/rq_pick.sv
module rq_pick #(
  parameter int DEPTH = 8,
  parameter int QOS_W = 2,
  parameter int SEQ_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH-1:0]             vld,
  input  logic [DEPTH-1:0]             wr,
  input  logic [DEPTH-1:0]             hit,
  input  logic [DEPTH-1:0][QOS_W-1:0]  qos,
  input  logic [DEPTH-1:0][SEQ_W-1:0]  age,
  output logic                         any,
  output logic [IDX_W-1:0]             win,
  output logic [IDX_W-1:0]             old,
  output rq_pkg::rq_reason_e           reason
);
  localparam int KEY_W = QOS_W + 2;

  logic [DEPTH-1:0][KEY_W-1:0] key;
  logic [KEY_W-1:0]            bkey;
  logic [SEQ_W-1:0]            bage;
  logic [SEQ_W-1:0]            oage;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) key[i] = {qos[i], hit[i], ~wr[i]};
  end

  always_comb begin
    any  = 1'b0;
    win  = '0;
    old  = '0;
    bkey = '0;
    bage = '0;
    oage = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i]) begin
        if (!any || key[i] > bkey || (key[i] == bkey && age[i] > bage)) begin
          win  = IDX_W'(i);
          bkey = key[i];
          bage = age[i];
        end
        if (!any || age[i] > oage) begin
          old  = IDX_W'(i);
          oage = age[i];
        end
        any = 1'b1;
      end
    end
  end

  always_comb begin
    if (win == old)                 reason = rq_pkg::RSN_OLDEST;
    else if (qos[win] != qos[old])  reason = rq_pkg::RSN_QOS;
    else if (hit[win] != hit[old])  reason = rq_pkg::RSN_ROWHIT;
    else                            reason = rq_pkg::RSN_READ;
  end

  // R5: the chosen slot holds a request and never ranks below the oldest
  p_win_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> vld[win]);
  p_win_rank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (key[win] >= key[old]));
  // R8: the oldest entry is valid and no valid entry is older
  p_old_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (vld[old] && age[old] >= age[win]));
endmodule

// File: rtl/rq_reorder_queue.sv
module rq_reorder_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int COL_W  = 4,
  parameter int BANK_W = 2,
  parameter int SRC_W  = 4,
  parameter int QOS_W  = 2,
  parameter int SEQ_W  = 8,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [QOS_W-1:0]  in_qos,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_write,
  output logic [ADDR_W-1:0] out_addr,
  output logic              log_valid,
  output logic [SEQ_W-1:0]  log_seq,
  output logic [TS_W-1:0]   log_stamp,
  output logic [SRC_W-1:0]  log_src,
  output logic [QOS_W-1:0]  log_qos,
  output logic [1:0]        log_reason,
  output logic              log_skipped
);
  localparam int ROW_W = ADDR_W - COL_W - BANK_W;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]              v_q, v_d, alloc_oh;
  logic [DEPTH-1:0]              wr_q;
  logic [DEPTH-1:0][ADDR_W-1:0]  addr_q;
  logic [DEPTH-1:0][SRC_W-1:0]   src_q;
  logic [DEPTH-1:0][QOS_W-1:0]   qos_q;
  logic [DEPTH-1:0][SEQ_W-1:0]   seq_q;
  logic [DEPTH-1:0][TS_W-1:0]    stamp_q;
  logic [DEPTH-1:0][SEQ_W-1:0]   age;
  logic [DEPTH-1:0][BANK_W-1:0]  ent_bank;
  logic [DEPTH-1:0][ROW_W-1:0]   ent_row;
  logic [DEPTH-1:0]              ent_hit;
  logic [SEQ_W-1:0]              seq_q_ctr, seq_d_ctr;
  logic [TS_W-1:0]               ts_q, ts_d;
  logic [CNT_W-1:0]              count_q, count_d;
  logic                          accept, fire, any;
  logic [IDX_W-1:0]              win, old;
  rq_pkg::rq_reason_e            reason;

  assign in_ready  = ~&v_q;
  assign accept    = in_valid && in_ready;
  assign out_valid = any;
  assign fire      = any && out_ready;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      age[i]      = seq_q_ctr - seq_q[i];
      ent_bank[i] = addr_q[i][COL_W +: BANK_W];
      ent_row[i]  = addr_q[i][ADDR_W-1 -: ROW_W];
    end
  end

  // lowest free slot receives the new request
  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!v_q[i] && !found) begin
        alloc_oh[i] = accept;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    v_d = v_q;
    if (fire) v_d[win] = 1'b0;
    v_d       = v_d | alloc_oh;
    seq_d_ctr = accept ? seq_q_ctr + SEQ_W'(1) : seq_q_ctr;
    ts_d      = ts_q + TS_W'(1);
    count_d   = count_q + CNT_W'(accept) - CNT_W'(fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q       <= '0;
      seq_q_ctr <= '0;
      ts_q      <= '0;
      count_q   <= '0;
    end else begin
      v_q       <= v_d;
      seq_q_ctr <= seq_d_ctr;
      ts_q      <= ts_d;
      count_q   <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      addr_q  <= '0;
      src_q   <= '0;
      qos_q   <= '0;
      seq_q   <= '0;
      stamp_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_oh[i]) begin
          wr_q[i]    <= in_write;
          addr_q[i]  <= in_addr;
          src_q[i]   <= in_src;
          qos_q[i]   <= in_qos;
          seq_q[i]   <= seq_q_ctr;
          stamp_q[i] <= ts_q;
        end
      end
    end
  end

  rq_open_rows #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (fire),
    .upd_bank (ent_bank[win]),
    .upd_row  (ent_row[win]),
    .ent_bank (ent_bank),
    .ent_row  (ent_row),
    .ent_hit  (ent_hit)
  );

  rq_pick #(.DEPTH(DEPTH), .QOS_W(QOS_W), .SEQ_W(SEQ_W)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld    (v_q),
    .wr     (wr_q),
    .hit    (ent_hit),
    .qos    (qos_q),
    .age    (age),
    .any    (any),
    .win    (win),
    .old    (old),
    .reason (reason)
  );

  assign out_write   = wr_q[win];
  assign out_addr    = addr_q[win];
  assign log_valid   = fire;
  assign log_seq     = seq_q[win];
  assign log_stamp   = stamp_q[win];
  assign log_src     = src_q[win];
  assign log_qos     = qos_q[win];
  assign log_reason  = reason;
  assign log_skipped = (win != old);

  // R1: room reported exactly while the occupancy count is below capacity
  p_ready_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (count_q != CNT_W'(DEPTH)));
  // R9: issue side offers a request exactly while something is held
  p_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (count_q != '0));
  // R2: one sequence step per accepted request
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (seq_q_ctr == $past(seq_q_ctr) + SEQ_W'(1)));

  for (genvar g = 0; g < DEPTH; g++) begin : g_hold
    // R3 (also R2, R4): a waiting entry keeps its tags and sideband
    p_entry_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[g] |=> (!v_q[g] || ($stable(stamp_q[g]) && $stable(seq_q[g]) &&
                               $stable(src_q[g]) && $stable(addr_q[g]))));
  end
endmodule

// File: tb/rq_reorder_queue_tb.sv
module rq_reorder_queue_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_write = 1'b0, out_ready = 1'b0;
  logic [15:0] in_addr = '0;
  logic [3:0]  in_src = '0;
  logic [1:0]  in_qos = '0;
  logic in_ready, out_valid, out_write, log_valid, log_skipped;
  logic [15:0] out_addr, log_stamp;
  logic [7:0]  log_seq;
  logic [3:0]  log_src;
  logic [1:0]  log_qos, log_reason;

  always #5 clk = ~clk;

  rq_reorder_queue u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_write(in_write), .in_addr(in_addr), .in_src(in_src), .in_qos(in_qos),
    .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
    .out_addr(out_addr), .log_valid(log_valid), .log_seq(log_seq),
    .log_stamp(log_stamp), .log_src(log_src), .log_qos(log_qos),
    .log_reason(log_reason), .log_skipped(log_skipped)
  );

  typedef struct {
    bit wr; int addr; int src; int qos; int seq; int stamp;
  } ment_t;

  ment_t mq[$];
  bit    ovld[4];
  int    orow[4];
  int    m_seq, m_ts;
  int    n_chk, n_err;
  int    seen[4];
  bit    done;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit mhit(ment_t e);
    int b = (e.addr >> 4) & 3;
    return ovld[b] && orow[b] == (e.addr >> 6);
  endfunction

  function automatic bit better(ment_t a, ment_t b);
    if (a.qos != b.qos) return a.qos > b.qos;
    if (mhit(a) != mhit(b)) return mhit(a);
    return (!a.wr) && b.wr;
  endfunction

  task automatic cyc(bit iv, bit iw, int ia, int is, int iq, bit ordy);
    bit exp_rdy, exp_ov, acc;
    int w, rsn;
    in_valid = iv; in_write = iw; in_addr = 16'(ia);
    in_src = 4'(is); in_qos = 2'(iq); out_ready = ordy;
    #1;
    exp_rdy = mq.size() < 8;
    exp_ov  = mq.size() > 0;
    chk(in_ready == exp_rdy, "R1 in_ready", int'(in_ready), int'(exp_rdy));
    chk(out_valid == exp_ov, "R9 out_valid", int'(out_valid), int'(exp_ov));
    chk(log_valid == (exp_ov && ordy), "R9 log_valid", int'(log_valid), int'(exp_ov && ordy));
    w = 0;
    if (exp_ov) begin
      for (int i = 1; i < mq.size(); i++) if (better(mq[i], mq[w])) w = i;
      chk(int'(out_addr) == mq[w].addr, "R5 out_addr", int'(out_addr), mq[w].addr);
      chk(out_write == mq[w].wr, "R4 out_write", int'(out_write), int'(mq[w].wr));
      if (ordy) begin
        if (w == 0) rsn = 0;
        else if (mq[w].qos != mq[0].qos) rsn = 1;
        else if (mhit(mq[w]) != mhit(mq[0])) rsn = 2;
        else rsn = 3;
        seen[rsn]++;
        chk(int'(log_seq) == mq[w].seq, "R2 log_seq", int'(log_seq), mq[w].seq);
        chk(int'(log_stamp) == mq[w].stamp, "R3 log_stamp", int'(log_stamp), mq[w].stamp);
        chk(int'(log_src) == mq[w].src, "R4 log_src", int'(log_src), mq[w].src);
        chk(int'(log_qos) == mq[w].qos, "R4 log_qos", int'(log_qos), mq[w].qos);
        chk(int'(log_reason) == rsn, "R7 log_reason", int'(log_reason), rsn);
        chk(log_skipped == (w != 0), "R8 log_skipped", int'(log_skipped), int'(w != 0));
      end
    end
    acc = iv && exp_rdy;
    if (exp_ov && ordy) begin
      ovld[(mq[w].addr >> 4) & 3] = 1'b1;
      orow[(mq[w].addr >> 4) & 3] = mq[w].addr >> 6;
      mq.delete(w);
    end
    if (acc) mq.push_back('{wr: iw, addr: ia & 16'hffff, src: is & 15, qos: iq & 3,
                            seq: m_seq, stamp: m_ts});
    if (acc) m_seq = (m_seq + 1) & 255;
    m_ts = (m_ts + 1) & 16'hffff;
    @(negedge clk);
  endtask

  function automatic int mk(int row, int bank, int col);
    return ((row & 1023) << 6) | ((bank & 3) << 4) | (col & 15);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
    chk(log_valid == 1'b0, "R9 reset log_valid", int'(log_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R9 reset state, then fill past capacity (9th request refused)
    cyc(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 9; i++) cyc(1, i[0], mk(i, i, i), i, 0, 0);
    cyc(1, 0, mk(77, 1, 0), 9, 3, 0);
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, 0, 1);
    // R5 R7: write then read in one bank, then row hits, then QoS jump
    cyc(1, 1, mk(40, 2, 0), 1, 0, 0);
    cyc(1, 0, mk(41, 2, 1), 2, 0, 0);
    cyc(1, 1, mk(50, 3, 0), 3, 0, 0);
    cyc(1, 1, mk(41, 2, 2), 4, 0, 0);
    cyc(1, 0, mk(60, 0, 0), 5, 2, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 1);
    // R6: open row steers later picks, no QoS
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      cyc(r < 60, $urandom_range(0, 1), mk($urandom_range(0, 2), $urandom_range(0, 3),
          $urandom_range(0, 15)), $urandom_range(0, 15), 0, $urandom_range(0, 99) < 45);
    end
    // mixed QoS traffic, long enough to wrap sequence numbers (R2)
    for (int n = 0; n < 6000; n++) begin
      cyc($urandom_range(0, 99) < 55, $urandom_range(0, 1),
          mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 15)),
          $urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 99) < 50);
    end
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 4; k++) chk(seen[k] > 0, "R7 reason code observed", seen[k], 1);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule